// File: doc/BRIEF.md
# Interleaved Recursive Accumulator

This block runs the first-order recursion y = x + a * y_prev for a set of independent data streams, all sharing one saturating adder and one rounding multiplier. Samples arrive time-interleaved, one per accepted cycle, cycling through the streams in a fixed round-robin order. The datapath runs at the stream count times the per-stream sample rate. Each stream then keeps its full sample rate, while the arithmetic is built only once.

The feedback loop holds exactly as many registers as there are streams. These are the adder stages, the multiplier stages and enough padding registers to make up the difference. The scaled result for a stream therefore comes back to the adder input at the moment that stream's next sample is accepted. The loop registers themselves hold every stream's state, so no separate state memory is needed.

The loop moves forward only on cycles that carry a sample. Idle cycles freeze it. Reset clears the state of every stream.

Top module: `ilv_recur_acc`

## Requirements
- R1: For each accepted sample, y_o equals clamp(x_i + rnd(coef_i * y_prev)), where y_prev is the previous output of the same stream.
- R2: valid_o is high in the cycle after each accepted sample (valid_i high at a rising edge) and low otherwise. During reset and directly after it, valid_o, y_o, stream_o and seq_err_o are all zero.
- R3: After reset, the previous output of every stream counts as zero. The first sample of each stream therefore comes out unchanged (y_o equals x_i).
- R4: A cycle with valid_i low does not advance the loop. It gives no output, and y_o and stream_o keep their last values. The next accepted sample carries on the recursion of the slot that was due.
- R5: Accepted samples are assigned to slots 0, 1, ..., N_STREAMS-1 and then back to 0, starting at 0 after reset. stream_o reports the slot of the current output.
- R6: seq_err_o is high together with valid_o when the stream_i of that sample differed from its slot. Such a sample is still processed as the slot that was due, and the recursion of the slot named by stream_i is left untouched. seq_err_o is low on idle cycles.
- R7: The sum x_i + feedback saturates to the signed DATA_W range, from -2^(DATA_W-1) to 2^(DATA_W-1)-1, instead of wrapping around.
- R8: coef_i is signed, with COEF_FRAC fractional bits, and is held constant between resets. The feedback equals floor((coef * y_prev + 2^(COEF_FRAC-1)) / 2^COEF_FRAC), clamped to the signed DATA_W range. Ties therefore round toward plus infinity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Sample present this cycle |
| stream_i | input | $clog2(N_STREAMS) | Stream index claimed by the sender |
| x_i | input | DATA_W | Signed input sample |
| coef_i | input | COEF_W | Signed feedback coefficient, COEF_FRAC fractional bits |
| valid_o | output | 1 | Output sample present |
| stream_o | output | $clog2(N_STREAMS) | Slot of the output sample |
| y_o | output | DATA_W | Signed output sample |
| seq_err_o | output | 1 | Claimed stream differed from the slot that was due |

## Verification
Every result appears one cycle after the accepted sample that causes it: valid_o, y_o, stream_o and seq_err_o all come from the adder's output register. A stream's feedback counts in accepted samples and not in clock cycles. The value fed back for a sample is the one produced N_STREAMS accepted samples earlier, however many idle cycles fall in between. The bench drives each sample on a falling edge and compares all four outputs with its behavioural per-stream model on the next falling edge. It runs the same comparison on idle cycles, where it expects the held values.

// File: rtl/ilv_recur_pkg.sv
package ilv_recur_pkg;

  // signed clamp of a wide value to a w-bit two's complement range
  function automatic longint clamp_w(input longint v, input int w);
    longint hi;
    longint lo;
    hi = (longint'(1) <<< (w - 1)) - 1;
    lo = -(longint'(1) <<< (w - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

endpackage

// File: rtl/ilv_delay.sv
module ilv_delay #(
  parameter int W = 16,
  parameter int D = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (D == 0) begin : g_pass
    assign q_o = d_i;
  end else begin : g_regs
    logic [W-1:0] r_q [D];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < D; i++) r_q[i] <= '0;
      end else if (en_i) begin
        r_q[0] <= d_i;
        for (int i = 1; i < D; i++) r_q[i] <= r_q[i-1];
      end
    end
    assign q_o = r_q[D-1];
  end
endmodule

// File: rtl/ilv_slot_seq.sv
module ilv_slot_seq #(
  parameter int N_STREAMS = 16,
  localparam int IdxW = $clog2(N_STREAMS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [IdxW-1:0] stream_i,
  output logic            valid_o,
  output logic [IdxW-1:0] stream_o,
  output logic            seq_err_o
);
  localparam logic [IdxW-1:0] LastSlot = IdxW'(N_STREAMS - 1);

  logic [IdxW-1:0] slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q    <= '0;
      valid_o   <= 1'b0;
      stream_o  <= '0;
      seq_err_o <= 1'b0;
    end else begin
      valid_o   <= valid_i;
      seq_err_o <= valid_i && (stream_i != slot_q);
      if (valid_i) begin
        stream_o <= slot_q;
        slot_q   <= (slot_q == LastSlot) ? '0 : slot_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ilv_add_sat.sv
module ilv_add_sat #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] fb_i,
  output logic [DATA_W-1:0] sum_o
);
  import ilv_recur_pkg::*;

  logic [DATA_W-1:0] sum_d;

  always_comb begin
    longint s;
    s = longint'($signed(x_i)) + longint'($signed(fb_i));
    sum_d = DATA_W'(clamp_w(s, DATA_W));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sum_o <= '0;
    else if (en_i) sum_o <= sum_d;
  end
endmodule

// File: rtl/ilv_mul_rnd.sv
module ilv_mul_rnd #(
  parameter int DATA_W    = 16,
  parameter int COEF_W    = 16,
  parameter int COEF_FRAC = 14,
  parameter int LAT       = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DATA_W-1:0] y_i,
  input  logic [COEF_W-1:0] coef_i,
  output logic [DATA_W-1:0] p_o
);
  import ilv_recur_pkg::*;

  localparam longint Half = longint'(1) <<< (COEF_FRAC - 1);

  logic [DATA_W-1:0] p_d;
  logic [DATA_W-1:0] p_q;

  always_comb begin
    longint p;
    p   = longint'($signed(y_i)) * longint'($signed(coef_i));
    p   = (p + Half) >>> COEF_FRAC;
    p_d = DATA_W'(clamp_w(p, DATA_W));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   p_q <= '0;
    else if (en_i) p_q <= p_d;
  end

  // remaining multiplier stages as retiming registers
  ilv_delay #(.W(DATA_W), .D(LAT - 1)) u_tail (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .d_i   (p_q),
    .q_o   (p_o)
  );
endmodule

// File: rtl/ilv_recur_acc.sv
module ilv_recur_acc #(
  parameter int N_STREAMS = 16,
  parameter int DATA_W    = 16,
  parameter int COEF_W    = 16,
  parameter int COEF_FRAC = 14,
  parameter int ADD_LAT   = 1,
  parameter int MUL_LAT   = 2,
  localparam int IdxW     = $clog2(N_STREAMS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [IdxW-1:0]   stream_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic [COEF_W-1:0] coef_i,
  output logic              valid_o,
  output logic [IdxW-1:0]   stream_o,
  output logic [DATA_W-1:0] y_o,
  output logic              seq_err_o
);
  // padding so the loop holds exactly one register per stream
  localparam int BalLat = N_STREAMS - ADD_LAT - MUL_LAT;

  logic [DATA_W-1:0] sum_q;
  logic [DATA_W-1:0] add_tail;
  logic [DATA_W-1:0] y_tail;
  logic [DATA_W-1:0] fb;

  ilv_slot_seq #(.N_STREAMS(N_STREAMS)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .stream_i (stream_i),
    .valid_o  (valid_o),
    .stream_o (stream_o),
    .seq_err_o(seq_err_o)
  );

  ilv_add_sat #(.DATA_W(DATA_W)) u_add (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (valid_i),
    .x_i   (x_i),
    .fb_i  (fb),
    .sum_o (sum_q)
  );

  ilv_delay #(.W(DATA_W), .D(ADD_LAT - 1)) u_add_tail (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (valid_i),
    .d_i   (sum_q),
    .q_o   (add_tail)
  );

  ilv_delay #(.W(DATA_W), .D(BalLat)) u_bal (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (valid_i),
    .d_i   (add_tail),
    .q_o   (y_tail)
  );

  ilv_mul_rnd #(
    .DATA_W   (DATA_W),
    .COEF_W   (COEF_W),
    .COEF_FRAC(COEF_FRAC),
    .LAT      (MUL_LAT)
  ) u_mul (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (valid_i),
    .y_i   (y_tail),
    .coef_i(coef_i),
    .p_o   (fb)
  );

  assign y_o = sum_q;
endmodule

// File: rtl/ilv_recur_chk.sv
module ilv_recur_chk #(
  parameter int N_STREAMS = 16,
  parameter int DATA_W    = 16,
  parameter int IdxW      = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [DATA_W-1:0] x_i,
  input logic              valid_o,
  input logic [IdxW-1:0]   stream_o,
  input logic [DATA_W-1:0] y_o,
  input logic              seq_err_o
);
  localparam int CntW = $clog2(N_STREAMS + 1);

  logic              vld_d;
  logic [DATA_W-1:0] x_d;
  logic [IdxW-1:0]   exp_slot;
  logic [CntW-1:0]   out_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_d    <= 1'b0;
      x_d      <= '0;
      exp_slot <= '0;
      out_cnt  <= '0;
    end else begin
      vld_d <= valid_i;
      if (valid_i) x_d <= x_i;
      if (valid_o) begin
        exp_slot <= (exp_slot == IdxW'(N_STREAMS - 1)) ? '0 : exp_slot + 1'b1;
        if (out_cnt < CntW'(N_STREAMS)) out_cnt <= out_cnt + 1'b1;
      end
    end
  end

  // R2
  out_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == vld_d);

  // R5
  slot_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> stream_o == exp_slot);

  // R6
  err_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_err_o |-> valid_o);

  // R4
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(y_o) && $stable(stream_o) && !valid_o));

  // R3
  first_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && out_cnt < CntW'(N_STREAMS)) |-> y_o == x_d);
endmodule

bind ilv_recur_acc ilv_recur_chk #(
  .N_STREAMS(N_STREAMS),
  .DATA_W   (DATA_W),
  .IdxW     (IdxW)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .x_i      (x_i),
  .valid_o  (valid_o),
  .stream_o (stream_o),
  .y_o      (y_o),
  .seq_err_o(seq_err_o)
);

// File: tb/ilv_recur_acc_test.sv
module ilv_recur_acc_test;
  localparam int CLK_PERIOD = 10;
  localparam int N    = 16;
  localparam int DW   = 16;
  localparam int CW   = 16;
  localparam int FRAC = 14;
  localparam int IW   = $clog2(N);
  localparam int MAXV = 32767;
  localparam int MINV = -32768;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [IW-1:0] stream_i = '0;
  logic [DW-1:0] x_i = '0;
  logic [CW-1:0] coef_i = '0;
  logic          valid_o;
  logic [IW-1:0] stream_o;
  logic [DW-1:0] y_o;
  logic          seq_err_o;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ilv_recur_acc #(
    .N_STREAMS(N), .DATA_W(DW), .COEF_W(CW), .COEF_FRAC(FRAC),
    .ADD_LAT(1), .MUL_LAT(2)
  ) uut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .stream_i(stream_i),
    .x_i(x_i), .coef_i(coef_i), .valid_o(valid_o), .stream_o(stream_o),
    .y_o(y_o), .seq_err_o(seq_err_o)
  );

  int total = 0;
  int fails = 0;
  bit done = 0;

  // behavioural model
  int st [N];
  int eslot;
  int coef_m;
  int exp_y, exp_s;
  bit exp_v, exp_e;

  function automatic int clampi(longint v);
    if (v > MAXV) return MAXV;
    if (v < MINV) return MINV;
    return int'(v);
  endfunction

  function automatic int rnd(int a, int y);
    longint p;
    p = longint'(a) * longint'(y);
    p = (p + (longint'(1) <<< (FRAC - 1))) >>> FRAC;
    return clampi(p);
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(valid_o == exp_v, tag, "valid_o", int'(valid_o), int'(exp_v));
    chk($signed(y_o) == exp_y, tag, "y_o", int'($signed(y_o)), exp_y);
    chk(int'(stream_o) == exp_s, tag, "stream_o", int'(stream_o), exp_s);
    chk(seq_err_o == exp_e, tag, "seq_err_o", int'(seq_err_o), int'(exp_e));
  endtask

  // drive on a falling edge, check on the next falling edge
  task automatic step(bit v, int sidx, int x, string tag);
    valid_i  = v;
    stream_i = IW'(sidx);
    x_i      = DW'(x);
    if (v) begin
      exp_y = clampi(longint'(x) + longint'(rnd(coef_m, st[eslot])));
      st[eslot] = exp_y;
      exp_s = eslot;
      exp_e = (sidx != eslot);
      exp_v = 1'b1;
      eslot = (eslot + 1) % N;
    end else begin
      exp_v = 1'b0;
      exp_e = 1'b0;
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic do_reset(int coef);
    valid_i = 1'b0;
    rst_ni  = 1'b0;
    coef_i  = CW'(coef);
    coef_m  = coef;
    for (int i = 0; i < N; i++) st[i] = 0;
    eslot = 0; exp_y = 0; exp_s = 0; exp_v = 0; exp_e = 0;
    repeat (2) @(negedge clk);
    compare("R2");
    rst_ni = 1'b1;
    @(negedge clk);
    compare("R2");
  endtask

  initial begin
    @(negedge clk);
    // R2: reset state, coefficient 0.5
    do_reset(8192);
    // R3: first pass returns inputs unchanged
    for (int s = 0; s < N; s++) step(1, s, 100 * (s + 1) - 900, "R3");
    // R1: several passes of pseudo-random data
    for (int p = 0; p < 3; p++)
      for (int s = 0; s < N; s++)
        step(1, s, int'($urandom_range(4000)) - 2000, "R1");
    // R4: idle cycles between samples freeze the loop
    for (int s = 0; s < N; s++) begin
      step(0, 0, 12345, "R4");
      if (s % 3 == 0) step(0, 0, -777, "R4");
      step(1, s, 50 * s - 300, "R4");
    end
    // R5: full passes with wrap from the last slot to 0
    for (int s = 0; s < N + 3; s++) step(1, s % N, s * 7, "R5");
    // R6: wrong stream index claimed, processed as the due slot
    for (int s = 0; s < N; s++) step(1, (s % 4 == 1) ? (s + 5) % N : (s + 3) % N, 333, "R6");
    for (int s = 0; s < N; s++) step(1, (s + 3) % N, -100, "R6");

    // R7: positive and negative saturation with coefficient 1.9
    do_reset(31130);
    for (int p = 0; p < 3; p++)
      for (int s = 0; s < N; s++)
        step(1, s, (s % 2 == 0) ? 20000 : -20000, "R7");
    for (int s = 0; s < N; s++) step(1, s, (s % 2 == 0) ? 32767 : -32768, "R7");

    // R8: half-LSB ties round toward plus infinity
    do_reset(8192);
    for (int s = 0; s < N; s++) step(1, s, (s % 2 == 0) ? 3 : -3, "R8");
    for (int s = 0; s < N; s++) step(1, s, 0, "R8");
    for (int s = 0; s < N; s++) step(1, s, 0, "R8");

    // R8: product overflow clamps (-2.0 * -32768)
    do_reset(-32768);
    for (int s = 0; s < N; s++) step(1, s, -32768, "R8");
    for (int s = 0; s < N; s++) step(1, s, 0, "R8");

    // R3: reset part way through a pass restarts at slot 0 with zero state
    do_reset(12288);
    for (int s = 0; s < 5; s++) step(1, s, 1000 + s, "R3");
    do_reset(12288);
    for (int s = 0; s < N; s++) step(1, s, -400 + s, "R3");
    for (int s = 0; s < N; s++) step(1, s, 10, "R1");

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule